// File: doc/BRIEF.md
# Parallel-Lane Progression Sieve

This block sieves a run of consecutive integer indices against a small set of arithmetic progressions. Each progression is an interval (step), a first index it hits, and an integer weight standing for the logarithm of its interval. Every index collects the weights of all progressions that land on it. Any index whose total is strictly above a threshold is reported with that total.

The engine handles `LANES` consecutive indices per clock. A group of indices (group base plus lane offset 0 to `LANES-1`) enters a chain of `STAGES` registered stages. Each stage owns one progression and adds its weight into every lane it hits. When the step is smaller than the lane count, one stage hits several lanes of a group. After each group, the stage moves its tracker past the group by whole steps. Behind the chain, a hold register compares all lanes with the threshold. Passing lanes are pushed one per cycle into a small FIFO that drives a valid/ready output. While the hold register still has lanes left to push, the chain stalls.

Progressions are loaded while the block is idle. A run is started with a base index, a group count and a threshold.

Top module: `sieve_pipe`

## Requirements
- R1: After reset, `busy_o` and `hit_valid_o` are low.
- R2: A run covers the indices from `base_i` to `base_i + groups_i*LANES - 1`. A stage loaded with step p > 0, first index f and weight w adds w to every index i of the run with i >= f and (i - f) divisible by p. The first index must not be below `base_i`.
- R3: A lane total saturates at 2^SUM_W - 1 and does not wrap.
- R4: An index is reported only if its total is strictly greater than the threshold latched at start. A total equal to the threshold is not reported.
- R5: With no index passing, `busy_o` stays high for at most `groups_i + STAGES + 3` cycles after start.
- R6: A step smaller than `LANES` hits every matching lane in the same group, with no index skipped.
- R7: A stage loaded with step 0 contributes nothing.
- R8: Reports leave in strictly ascending index order. While `hit_valid_o` is high and `hit_ready_i` is low, the index and total hold stable.
- R9: Holding `hit_ready_i` low stalls the pipeline, and no report is lost or duplicated.
- R10: A progression write (`cfg_we_i`) or a `start_i` pulse while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Load the progression of the selected stage (idle only) |
| cfg_sel_i | input | $clog2(STAGES) | Stage selected for loading |
| cfg_step_i | input | P_W | Progression step; 0 disables the stage |
| cfg_first_i | input | IDX_W | First index hit by the progression |
| cfg_wt_i | input | WT_W | Weight added per hit |
| start_i | input | 1 | Start a run (idle only) |
| base_i | input | IDX_W | First index of the run |
| groups_i | input | IDX_W | Number of index groups in the run |
| thr_i | input | SUM_W | Report threshold |
| busy_o | output | 1 | Run in progress or reports pending |
| hit_valid_o | output | 1 | Report available |
| hit_ready_i | input | 1 | Consumer accepts report |
| hit_idx_o | output | IDX_W | Reported index |
| hit_sum_o | output | SUM_W | Reported total |

## Verification
The sieve is driven with mixed prime-like steps whose hits overlap on some indices. This shows whether the weights of several stages are summed correctly across lanes. Steps of 1, 2 and 3 against four lanes test multiple hits within one group, and a disabled stage with a large weight shows whether step 0 really masks it. Stacked heavy weights and a threshold equal to a single weight separate saturation from wrapping and `>` from `>=`. An all-pass run with a long ready stall, runs on random progression sets with unaligned bases, and a run with a write and start attempted mid-run separate correct stalling and idle-gating from lost, repeated or corrupted reports.

// File: rtl/sieve_pkg.sv
package sieve_pkg;
  parameter int unsigned DEF_LANES  = 4;
  parameter int unsigned DEF_STAGES = 6;
  parameter int unsigned DEF_IDX_W  = 16;
  parameter int unsigned DEF_P_W    = 8;
  parameter int unsigned DEF_WT_W   = 8;
  parameter int unsigned DEF_SUM_W  = 8;
  parameter int unsigned DEF_FIFO_D = 4;
endpackage

// File: rtl/sieve_stage.sv
module sieve_stage
  import sieve_pkg::*;
#(
  parameter int unsigned LANES = DEF_LANES,
  parameter int unsigned IDX_W = DEF_IDX_W,
  parameter int unsigned P_W   = DEF_P_W,
  parameter int unsigned WT_W  = DEF_WT_W,
  parameter int unsigned SUM_W = DEF_SUM_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cfg_we_i,
  input  logic [P_W-1:0]                  cfg_step_i,
  input  logic [IDX_W-1:0]                cfg_first_i,
  input  logic [WT_W-1:0]                 cfg_wt_i,
  input  logic                            adv_i,
  input  logic                            in_valid_i,
  input  logic [IDX_W-1:0]                in_base_i,
  input  logic [LANES-1:0][SUM_W-1:0]     in_sums_i,
  output logic                            out_valid_o,
  output logic [IDX_W-1:0]                out_base_o,
  output logic [LANES-1:0][SUM_W-1:0]     out_sums_o
);
  localparam int unsigned LW = $clog2(LANES);
  localparam int unsigned CW = $clog2(LANES + 1);
  localparam int unsigned EW = IDX_W + P_W + LW + 1;

  logic [P_W-1:0]   step_q;
  logic [IDX_W-1:0] next_q;
  logic [WT_W-1:0]  wt_q;

  logic [LANES-1:0]            hit_mask;
  logic [CW-1:0]               nhits;
  logic [EW-1:0]               next_nxt;
  logic [LANES-1:0][SUM_W-1:0] sum_nxt;

  // unrolled hit walk: at most LANES hits per group
  always_comb begin : walk
    logic [EW-1:0] pos;
    logic [EW-1:0] off;
    hit_mask = '0;
    nhits    = '0;
    for (int j = 0; j < LANES; j++) begin
      pos = EW'(next_q) + EW'(j) * EW'(step_q);
      off = pos - EW'(in_base_i);
      if (step_q != '0 && pos >= EW'(in_base_i) && pos < EW'(in_base_i) + EW'(LANES)) begin
        hit_mask[off[LW-1:0]] = 1'b1;
        nhits = nhits + CW'(1);
      end
    end
    next_nxt = EW'(next_q) + EW'(nhits) * EW'(step_q);
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      logic [SUM_W:0] ext;
      ext = {1'b0, in_sums_i[l]} + (hit_mask[l] ? (SUM_W+1)'(wt_q) : '0);
      sum_nxt[l] = ext[SUM_W] ? '1 : ext[SUM_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q      <= '0;
      next_q      <= '0;
      wt_q        <= '0;
      out_valid_o <= 1'b0;
      out_base_o  <= '0;
      out_sums_o  <= '0;
    end else begin
      if (cfg_we_i) begin
        step_q <= cfg_step_i;
        next_q <= cfg_first_i;
        wt_q   <= cfg_wt_i;
      end else if (adv_i && in_valid_i) begin
        next_q <= next_nxt[IDX_W-1:0];
      end
      if (adv_i) begin
        out_valid_o <= in_valid_i;
        out_base_o  <= in_base_i;
        out_sums_o  <= sum_nxt;
      end
    end
  end

  // R2: tracker never falls behind the group it meets
  p_tracker_ahead_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && in_valid_i && step_q != '0 |-> EW'(next_q) >= EW'(in_base_i));

  // R6: after a group the tracker sits past it
  p_step_past_group_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && in_valid_i && step_q != '0 && !cfg_we_i
    |=> EW'(next_q) >= EW'($past(in_base_i)) + EW'(LANES));

  for (genvar l = 0; l < LANES; l++) begin : g_sat_chk
    // R3: a lane total never decreases through a stage
    p_no_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adv_i && in_valid_i |=> out_sums_o[l] >= $past(in_sums_i[l]));
  end
endmodule

// File: rtl/sieve_hit_fifo.sv
module sieve_hit_fifo
  import sieve_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_FIFO_D,
  parameter int unsigned W     = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = cnt_q == CW'(DEPTH);
  assign empty_o = cnt_q == '0;
  assign data_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= data_i;
        wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
      end
      if (do_pop) rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  // R9: writer never offers data into a full queue
  p_no_push_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
endmodule

// File: rtl/sieve_pipe.sv
module sieve_pipe
  import sieve_pkg::*;
#(
  parameter int unsigned LANES      = DEF_LANES,
  parameter int unsigned STAGES     = DEF_STAGES,
  parameter int unsigned IDX_W      = DEF_IDX_W,
  parameter int unsigned P_W        = DEF_P_W,
  parameter int unsigned WT_W       = DEF_WT_W,
  parameter int unsigned SUM_W      = DEF_SUM_W,
  parameter int unsigned FIFO_DEPTH = DEF_FIFO_D
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_we_i,
  input  logic [$clog2(STAGES)-1:0]  cfg_sel_i,
  input  logic [P_W-1:0]             cfg_step_i,
  input  logic [IDX_W-1:0]           cfg_first_i,
  input  logic [WT_W-1:0]            cfg_wt_i,
  input  logic                       start_i,
  input  logic [IDX_W-1:0]           base_i,
  input  logic [IDX_W-1:0]           groups_i,
  input  logic [SUM_W-1:0]           thr_i,
  output logic                       busy_o,
  output logic                       hit_valid_o,
  input  logic                       hit_ready_i,
  output logic [IDX_W-1:0]           hit_idx_o,
  output logic [SUM_W-1:0]           hit_sum_o
);
  localparam int unsigned SEL_W = $clog2(STAGES);
  localparam int unsigned LW    = $clog2(LANES);
  localparam int unsigned FW    = IDX_W + SUM_W;

  logic [IDX_W-1:0] cur_q, left_q;
  logic [SUM_W-1:0] thr_q;
  logic             adv, cfg_ok, start_ok;

  logic                        st_valid [STAGES+1];
  logic [IDX_W-1:0]            st_base  [STAGES+1];
  logic [LANES-1:0][SUM_W-1:0] st_sums  [STAGES+1];
  logic [STAGES-1:0]           vld_vec;

  assign st_valid[0] = left_q != '0;
  assign st_base[0]  = cur_q;
  assign st_sums[0]  = '0;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    sieve_stage #(
      .LANES(LANES), .IDX_W(IDX_W), .P_W(P_W), .WT_W(WT_W), .SUM_W(SUM_W)
    ) u_stage (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_we_i    (cfg_ok && cfg_sel_i == SEL_W'(k)),
      .cfg_step_i  (cfg_step_i),
      .cfg_first_i (cfg_first_i),
      .cfg_wt_i    (cfg_wt_i),
      .adv_i       (adv),
      .in_valid_i  (st_valid[k]),
      .in_base_i   (st_base[k]),
      .in_sums_i   (st_sums[k]),
      .out_valid_o (st_valid[k+1]),
      .out_base_o  (st_base[k+1]),
      .out_sums_o  (st_sums[k+1])
    );
    assign vld_vec[k] = st_valid[k+1];
  end

  // hold register: threshold result of the last group, drained one lane per cycle
  logic [IDX_W-1:0]            h_base_q;
  logic [LANES-1:0][SUM_W-1:0] h_sums_q;
  logic [LANES-1:0]            h_mask_q, pass_mask, pick_oh, mask_after;
  logic [LW-1:0]               pick_lane;
  logic                        push, fifo_full, fifo_empty;
  logic [FW-1:0]               fifo_out;

  always_comb begin
    for (int l = 0; l < LANES; l++)
      pass_mask[l] = st_valid[STAGES] && (st_sums[STAGES][l] > thr_q);
  end

  always_comb begin
    pick_lane = '0;
    for (int l = LANES - 1; l >= 0; l--)
      if (h_mask_q[l]) pick_lane = LW'(l);
    pick_oh = '0;
    pick_oh[pick_lane] = 1'b1;
  end

  assign push       = (h_mask_q != '0) && !fifo_full;
  assign mask_after = push ? (h_mask_q & ~pick_oh) : h_mask_q;
  assign adv        = mask_after == '0;

  sieve_hit_fifo #(.DEPTH(FIFO_DEPTH), .W(FW)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  ({h_base_q + IDX_W'(pick_lane), h_sums_q[pick_lane]}),
    .full_o  (fifo_full),
    .pop_i   (hit_ready_i),
    .data_o  (fifo_out),
    .empty_o (fifo_empty)
  );

  assign hit_valid_o = !fifo_empty;
  assign hit_idx_o   = fifo_out[FW-1:SUM_W];
  assign hit_sum_o   = fifo_out[SUM_W-1:0];

  assign busy_o   = (left_q != '0) || (vld_vec != '0) || (h_mask_q != '0) || !fifo_empty;
  assign cfg_ok   = cfg_we_i && !busy_o;
  assign start_ok = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q    <= '0;
      left_q   <= '0;
      thr_q    <= '0;
      h_base_q <= '0;
      h_sums_q <= '0;
      h_mask_q <= '0;
    end else begin
      if (start_ok) begin
        cur_q  <= base_i;
        left_q <= groups_i;
        thr_q  <= thr_i;
      end else if (adv && left_q != '0) begin
        cur_q  <= cur_q + IDX_W'(LANES);
        left_q <= left_q - IDX_W'(1);
      end
      if (adv) begin
        h_base_q <= st_base[STAGES];
        h_sums_q <= st_sums[STAGES];
        h_mask_q <= pass_mask;
      end else begin
        h_mask_q <= mask_after;
      end
    end
  end

  // R8: offered report holds while the consumer stalls
  p_hold_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_valid_o && !hit_ready_i |=> hit_valid_o && $stable(hit_idx_o) && $stable(hit_sum_o));

  // R4: every offered total is above the latched threshold
  p_above_thr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_valid_o |-> hit_sum_o > thr_q);

  // R10: a run in flight keeps its threshold
  p_thr_locked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(thr_q));
endmodule

// File: tb/sieve_pipe_tb_top.sv
`timescale 1ns/1ps
module sieve_pipe_tb_top;
  localparam int LANES = 4, STAGES = 6, IDX_W = 16, P_W = 8, WT_W = 8, SUM_W = 8;
  localparam int SMAX = 255;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, start = 1'b0, ready = 1'b1;
  logic [2:0] cfg_sel = '0;
  logic [P_W-1:0] cfg_step = '0;
  logic [IDX_W-1:0] cfg_first = '0, base = '0, groups = '0;
  logic [WT_W-1:0] cfg_wt = '0;
  logic [SUM_W-1:0] thr = '0;
  logic busy, hv;
  logic [IDX_W-1:0] hidx;
  logic [SUM_W-1:0] hsum;

  always #2 clk = ~clk;

  sieve_pipe dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_step_i(cfg_step), .cfg_first_i(cfg_first), .cfg_wt_i(cfg_wt),
    .start_i(start), .base_i(base), .groups_i(groups), .thr_i(thr),
    .busy_o(busy), .hit_valid_o(hv), .hit_ready_i(ready),
    .hit_idx_o(hidx), .hit_sum_o(hsum)
  );

  int errors = 0, checks = 0;
  int m_step[STAGES], m_first[STAGES], m_wt[STAGES];
  int rx_idx[512], rx_sum[512];
  int rx_n, stall_bad, busy_cyc;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load(input int k, input int p, input int first, input int wt);
    m_step[k] = p; m_first[k] = first; m_wt[k] = wt;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(k); cfg_step = P_W'(p);
    cfg_first = IDX_W'(first); cfg_wt = WT_W'(wt);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_all();
    for (int k = 0; k < STAGES; k++) load(k, 0, 0, 0);
  endtask

  function automatic int exp_sum(input int i);
    int s = 0;
    for (int k = 0; k < STAGES; k++)
      if (m_step[k] != 0 && i >= m_first[k] && ((i - m_first[k]) % m_step[k]) == 0)
        s += m_wt[k];
    return (s > SMAX) ? SMAX : s;
  endfunction

  // mode 0: always ready; mode 1: long stall then sparse ready
  task automatic run(input int b, input int g, input int t, input int mode, input bit poke);
    bit prev_stall = 0;
    int prev_i = 0, prev_s = 0;
    rx_n = 0; stall_bad = 0; busy_cyc = 0;
    @(negedge clk);
    base = IDX_W'(b); groups = IDX_W'(g); thr = SUM_W'(t); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 5000; cyc++) begin
      ready = (mode == 0) ? 1'b1 : (cyc >= 40 && (cyc % 3) != 0);
      if (poke && cyc == 3) begin
        cfg_we = 1'b1; cfg_sel = 3'd0; cfg_step = 8'd1;
        cfg_first = IDX_W'(b); cfg_wt = 8'd200; start = 1'b1; base = IDX_W'(b + 4);
      end else begin
        cfg_we = 1'b0; start = 1'b0;
      end
      #1;
      if (prev_stall && !(hv && int'(hidx) == prev_i && int'(hsum) == prev_s)) stall_bad++;
      prev_stall = hv && !ready;
      prev_i = int'(hidx); prev_s = int'(hsum);
      if (hv && ready && rx_n < 512) begin
        rx_idx[rx_n] = int'(hidx); rx_sum[rx_n] = int'(hsum); rx_n++;
      end
      if (busy) busy_cyc++;
      if (!busy && !hv) break;
      @(negedge clk);
    end
    cfg_we = 1'b0; start = 1'b0; ready = 1'b1;
  endtask

  task automatic compare(input int b, input int g, input int t, input string req);
    int n = 0;
    int ei[512], es[512];
    for (int i = b; i < b + g * LANES; i++)
      if (exp_sum(i) > t && n < 512) begin ei[n] = i; es[n] = exp_sum(i); n++; end
    check(rx_n == n, req, "report count", rx_n, n);
    for (int k = 0; k < n && k < rx_n; k++) begin
      check(rx_idx[k] == ei[k], req, "report index", rx_idx[k], ei[k]);
      check(rx_sum[k] == es[k], req, "report total", rx_sum[k], es[k]);
    end
    check(stall_bad == 0, "R8", "stall stability violations", stall_bad, 0);
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    check(hv == 1'b0, "R1", "hit_valid after reset", int'(hv), 0);
  endtask

  task automatic t_mixed();  // R2, R7
    load(0, 2, 100, 10); load(1, 3, 102, 20); load(2, 5, 100, 30);
    load(3, 7, 105, 40); load(4, 11, 110, 50); load(5, 0, 100, 250);
    run(100, 10, 60, 0, 0);
    compare(100, 10, 60, "R2");
    check(exp_sum(101) == 0 && rx_n > 0 && rx_idx[0] != 101, "R7", "disabled stage index 101", rx_idx[0], 100);
  endtask

  task automatic t_small_step();  // R6
    clear_all();
    load(0, 1, 40, 5); load(1, 2, 41, 20); load(2, 3, 40, 30);
    run(40, 8, 30, 0, 0);
    compare(40, 8, 30, "R6");
  endtask

  task automatic t_sat();  // R3
    clear_all();
    load(0, 4, 300, 100); load(1, 4, 300, 100); load(2, 4, 300, 100); load(3, 8, 302, 90);
    run(300, 6, 200, 0, 0);
    compare(300, 6, 200, "R3");
    check(rx_n > 0 && rx_sum[0] == SMAX, "R3", "stacked total", rx_sum[0], SMAX);
  endtask

  task automatic t_thr();  // R4
    clear_all();
    load(0, 4, 500, 50);
    run(500, 5, 50, 0, 0);
    check(rx_n == 0, "R4", "equal-to-threshold reports", rx_n, 0);
    load(0, 4, 500, 50);
    run(500, 5, 49, 0, 0);
    compare(500, 5, 49, "R4");
  endtask

  task automatic t_backpressure();  // R8, R9
    clear_all();
    load(0, 1, 600, 100); load(1, 2, 600, 10);
    run(600, 10, 50, 1, 0);
    compare(600, 10, 50, "R9");
    for (int k = 1; k < rx_n; k++)
      if (rx_idx[k] <= rx_idx[k-1]) check(0, "R8", "ascending order", rx_idx[k], rx_idx[k-1] + 1);
  endtask

  task automatic t_no_pass();  // R5
    clear_all();
    load(0, 3, 700, 40);
    run(700, 20, 255, 0, 0);
    check(rx_n == 0, "R5", "reports in no-pass run", rx_n, 0);
    check(busy_cyc <= 20 + STAGES + 3, "R5", "busy cycles", busy_cyc, 20 + STAGES + 3);
  endtask

  task automatic t_busy_ignore();  // R10
    clear_all();
    load(0, 2, 800, 10); load(1, 3, 800, 60); load(2, 5, 801, 30);
    run(800, 12, 60, 0, 1);
    compare(800, 12, 60, "R10");
  endtask

  task automatic t_random();  // R2, R6
    for (int r = 0; r < 6; r++) begin
      int b = 1000 + r * 97;
      for (int k = 0; k < STAGES; k++)
        load(k, ($urandom_range(0, 5) == 0) ? 0 : int'($urandom_range(1, 13)),
             b + int'($urandom_range(0, 12)), int'($urandom_range(10, 90)));
      begin
        int t = int'($urandom_range(60, 150));
        run(b, 12, t, r % 2, 0);
        compare(b, 12, t, "R2");
      end
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mixed();
    t_small_step();
    t_sat();
    t_thr();
    t_backpressure();
    t_no_pass();
    t_busy_ignore();
    t_random();
    finish_up();
  end
endmodule